// File: doc/BRIEF.md
# Debug Register Access Trap Router

This block decides, for one access to a debug system register, whether the access may proceed or must be diverted to a higher exception level. The caller supplies the current exception level, the category of the register being touched, and the relevant trap-enable bits from the level-1, level-2 and level-3 debug and hypervisor controls. The block returns a 3-bit verdict. Register storage and the act of taking the exception belong to the surrounding pipeline.

Each register category draws on its own mix of trap bits. The levels are tested in a fixed order, lowest first, so the nearest level that claims the access wins. The comms-channel category adds a level-1 test ahead of the others. Its dedicated level-2 and level-3 trap bits only count when the fine-grained-trap feature is present. A category for registers that must appear absent always yields the undefined verdict. A separate category covers the 32-bit vector-catch save register, which can only trap from level 2. The verdict normally leaves through one register stage. That stage can be removed by a parameter when the caller wants it in the same cycle.

Top module: `dbg_trap_router`

## Requirements
- R1: Category codes are 0 power-down, 1 debug-ROM, 2 general, 3 comms, 4 always-undefined and 5 vector-catch save. Codes 4, 6 and 7 always give verdict 4 (UNDEFINED), whatever the other inputs are.
- R2: For categories 0, 1 and 2 at level 0 or 1, the verdict is 2 (TRAP_EL2) if the category's level-2 trap bit, the level-2 debug-routing bit or the hypervisor trap-general bit is set.
- R3: For categories 0, 1 and 2, when R2 does not apply and the level is below 3, the verdict is 3 (TRAP_EL3) if the category's level-3 trap bit is set. Category 0 uses the level-3 power-down bit. Categories 1 and 2 use the level-3 debug-access bit.
- R4: Category 1 uses the level-2 ROM trap bit at level 2, not the level-2 debug-access bit. It uses the level-3 debug-access bit at level 3.
- R5: For category 3 at level 0, if bit COMMS_TRAP_BIT (default 12) of the level-1 monitor control word is set, the verdict is 1 (TRAP_EL1), taking priority over every level-2 and level-3 condition.
- R6: For category 3, the level-2 condition is the level-2 debug-access bit OR the routing bit OR the trap-general bit OR (feature flag AND the level-2 comms bit). The level-3 condition is the level-3 debug-access bit OR (feature flag AND the level-3 comms bit). With the feature flag clear, both comms bits are ignored.
- R7: For category 3, the level-3 trap is gated by the "at level 3 or monitor" flag being clear, not by comparing the level with 3.
- R8: For category 5, the verdict is 3 only when the level is 2 and the level-3 debug-access bit is set. Otherwise it is 0 (OK).
- R9: When no condition applies, the verdict is 0 (OK). In particular, categories 0 to 2 never trap at level 3.
- R10: With REG_OUT=1 (default), the verdict for inputs presented before a rising clock edge appears after that edge. Synchronous reset sets the output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| cur_lvl_i | input | 2 | Current exception level 0..3 |
| reg_class_i | input | 3 | Register category code |
| l2_pwr_trap_i | input | 1 | Level-2 power-down register trap enable |
| l2_rom_trap_i | input | 1 | Level-2 debug-ROM register trap enable |
| l2_dbg_trap_i | input | 1 | Level-2 general debug-access trap enable |
| l2_comms_trap_i | input | 1 | Level-2 dedicated comms trap enable |
| l2_route_dbg_i | input | 1 | Level-2 debug-exception routing enable |
| hyp_tge_i | input | 1 | Hypervisor trap-general-exceptions bit |
| l3_pwr_trap_i | input | 1 | Level-3 power-down register trap enable |
| l3_dbg_trap_i | input | 1 | Level-3 general debug-access trap enable |
| l3_comms_trap_i | input | 1 | Level-3 dedicated comms trap enable |
| l1_mon_ctrl_i | input | MON_W | Level-1 monitor debug control word |
| fgt_present_i | input | 1 | Fine-grained-trap feature present |
| at_l3_or_mon_i | input | 1 | Core is at level 3 or in monitor mode |
| result_o | output | 3 | Verdict: 0 OK, 1 TRAP_EL1, 2 TRAP_EL2, 3 TRAP_EL3, 4 UNDEFINED |

## Verification
The block has no state beyond the output register, so a wrong condition shows up as a wrong verdict one clock after the offending input combination. Nothing builds up over time. A bad category decode or a swapped trap bit shows only for the input mixes where that bit decides the outcome. For this reason the stimulus varies each trap bit on its own across every level and category, and the expected verdict is derived independently for every vector. Priority slips, such as level 3 beating level 2 or the comms level-1 check losing, show up as a neighbouring code.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;

  localparam int CLS_W = 3;
  localparam int RES_W = 3;
  localparam int LVL_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_PWRDN   = 3'd0,
    CLS_ROM     = 3'd1,
    CLS_GENERAL = 3'd2,
    CLS_COMMS   = 3'd3,
    CLS_UNDEF   = 3'd4,
    CLS_VCSAVE  = 3'd5
  } cls_e;

  typedef enum logic [RES_W-1:0] {
    RES_OK    = 3'd0,
    RES_EL1   = 3'd1,
    RES_EL2   = 3'd2,
    RES_EL3   = 3'd3,
    RES_UNDEF = 3'd4
  } res_e;

  typedef struct packed {
    logic pwr;
    logic rom;
    logic dbg;
    logic comms;
    logic route;
    logic tge;
  } l2_bits_t;

  typedef struct packed {
    logic pwr;
    logic dbg;
    logic comms;
  } l3_bits_t;

endpackage

// File: rtl/dbg_l2_gate.sv
module dbg_l2_gate
  import dbg_trap_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  l2_bits_t         bits_i,
  input  logic             fgt_i,
  output logic             hit_o
);

  logic any_route;
  assign any_route = bits_i.route | bits_i.tge;

  always_comb begin
    case (cls_i)
      CLS_PWRDN:   hit_o = bits_i.pwr | any_route;
      CLS_ROM:     hit_o = bits_i.rom | any_route;
      CLS_GENERAL: hit_o = bits_i.dbg | any_route;
      CLS_COMMS:   hit_o = bits_i.dbg | any_route | (fgt_i & bits_i.comms);
      default:     hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_l3_gate.sv
module dbg_l3_gate
  import dbg_trap_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  l3_bits_t         bits_i,
  input  logic             fgt_i,
  output logic             hit_o
);

  always_comb begin
    case (cls_i)
      CLS_PWRDN:   hit_o = bits_i.pwr;
      CLS_ROM,
      CLS_GENERAL,
      CLS_VCSAVE:  hit_o = bits_i.dbg;
      CLS_COMMS:   hit_o = bits_i.dbg | (fgt_i & bits_i.comms);
      default:     hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_trap_prio.sv
module dbg_trap_prio
  import dbg_trap_pkg::*;
(
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             l1_hit_i,
  input  logic             l2_hit_i,
  input  logic             l3_hit_i,
  input  logic             at_top_i,
  output logic [RES_W-1:0] res_o
);

  logic below2, below3, at0, at2;
  assign below2 = (lvl_i < 2'd2);
  assign below3 = (lvl_i != 2'd3);
  assign at0    = (lvl_i == 2'd0);
  assign at2    = (lvl_i == 2'd2);

  always_comb begin
    res_o = RES_OK;
    case (cls_i)
      CLS_PWRDN, CLS_ROM, CLS_GENERAL: begin
        if (below2 && l2_hit_i)      res_o = RES_EL2;
        else if (below3 && l3_hit_i) res_o = RES_EL3;
      end
      CLS_COMMS: begin
        if (at0 && l1_hit_i)           res_o = RES_EL1;
        else if (below2 && l2_hit_i)   res_o = RES_EL2;
        else if (!at_top_i && l3_hit_i) res_o = RES_EL3;
      end
      CLS_VCSAVE: begin
        if (at2 && l3_hit_i) res_o = RES_EL3;
      end
      default: res_o = RES_UNDEF;
    endcase
  end

endmodule

// File: rtl/dbg_trap_router.sv
module dbg_trap_router
  import dbg_trap_pkg::*;
#(
  parameter int MON_W          = 32,
  parameter int COMMS_TRAP_BIT = 12,
  parameter bit REG_OUT        = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LVL_W-1:0]     cur_lvl_i,
  input  logic [CLS_W-1:0]     reg_class_i,
  input  logic                 l2_pwr_trap_i,
  input  logic                 l2_rom_trap_i,
  input  logic                 l2_dbg_trap_i,
  input  logic                 l2_comms_trap_i,
  input  logic                 l2_route_dbg_i,
  input  logic                 hyp_tge_i,
  input  logic                 l3_pwr_trap_i,
  input  logic                 l3_dbg_trap_i,
  input  logic                 l3_comms_trap_i,
  input  logic [MON_W-1:0]     l1_mon_ctrl_i,
  input  logic                 fgt_present_i,
  input  logic                 at_l3_or_mon_i,
  output logic [RES_W-1:0]     result_o
);

  localparam int BIT_SEL = (COMMS_TRAP_BIT < MON_W) ? COMMS_TRAP_BIT : MON_W - 1;

  l2_bits_t l2_bits;
  l3_bits_t l3_bits;
  logic l1_hit, l2_hit, l3_hit;
  logic [RES_W-1:0] verdict;

  assign l2_bits = '{pwr: l2_pwr_trap_i, rom: l2_rom_trap_i, dbg: l2_dbg_trap_i,
                     comms: l2_comms_trap_i, route: l2_route_dbg_i, tge: hyp_tge_i};
  assign l3_bits = '{pwr: l3_pwr_trap_i, dbg: l3_dbg_trap_i, comms: l3_comms_trap_i};
  assign l1_hit  = l1_mon_ctrl_i[BIT_SEL];

  dbg_l2_gate u_l2 (
    .cls_i (reg_class_i),
    .bits_i(l2_bits),
    .fgt_i (fgt_present_i),
    .hit_o (l2_hit)
  );

  dbg_l3_gate u_l3 (
    .cls_i (reg_class_i),
    .bits_i(l3_bits),
    .fgt_i (fgt_present_i),
    .hit_o (l3_hit)
  );

  dbg_trap_prio u_prio (
    .lvl_i   (cur_lvl_i),
    .cls_i   (reg_class_i),
    .l1_hit_i(l1_hit),
    .l2_hit_i(l2_hit),
    .l3_hit_i(l3_hit),
    .at_top_i(at_l3_or_mon_i),
    .res_o   (verdict)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [RES_W-1:0] res_q;
      always_ff @(posedge clk) begin
        if (rst) res_q <= RES_OK;
        else     res_q <= verdict;
      end
      assign result_o = res_q;

      AST_UNDEF_CLASS: assert property (@(posedge clk) disable iff (rst)
        (reg_class_i == CLS_UNDEF || reg_class_i > CLS_VCSAVE) |=> result_o == RES_UNDEF); // R1
      AST_EL2_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (reg_class_i <= CLS_GENERAL && cur_lvl_i < 2'd2 && (l2_route_dbg_i || hyp_tge_i))
        |=> result_o == RES_EL2); // R2
      AST_EL1_FIRST: assert property (@(posedge clk) disable iff (rst)
        (reg_class_i == CLS_COMMS && cur_lvl_i == 2'd0 && l1_mon_ctrl_i[BIT_SEL])
        |=> result_o == RES_EL1); // R5
      AST_VCSAVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (reg_class_i == CLS_VCSAVE && cur_lvl_i != 2'd2) |=> result_o == RES_OK); // R8
      AST_TOP_LEVEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (reg_class_i <= CLS_GENERAL && cur_lvl_i == 2'd3) |=> result_o == RES_OK); // R9
      AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> result_o <= RES_UNDEF); // R10
    end else begin : g_comb
      assign result_o = verdict;
    end
  endgenerate

endmodule

// File: tb/tb_dbg_trap_router.sv
`timescale 1ns/1ps
module tb_dbg_trap_router;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cur_lvl;
  logic [2:0] cls;
  logic l2p, l2r, l2d, l2c, l2rt, tge, l3p, l3d, l3c, fgt, attop;
  logic [31:0] mon;
  logic [2:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_trap_router dut (
    .clk(clk), .rst(rst), .cur_lvl_i(cur_lvl), .reg_class_i(cls),
    .l2_pwr_trap_i(l2p), .l2_rom_trap_i(l2r), .l2_dbg_trap_i(l2d),
    .l2_comms_trap_i(l2c), .l2_route_dbg_i(l2rt), .hyp_tge_i(tge),
    .l3_pwr_trap_i(l3p), .l3_dbg_trap_i(l3d), .l3_comms_trap_i(l3c),
    .l1_mon_ctrl_i(mon), .fgt_present_i(fgt), .at_l3_or_mon_i(attop),
    .result_o(result)
  );

  function automatic logic [2:0] model();
    logic l2h, l3h;
    if (cls == 3'd5) return (cur_lvl == 2'd2 && l3d) ? 3'd3 : 3'd0;      // R8
    if (cls >= 3'd4) return 3'd4;                                         // R1
    if (cls == 3'd3) begin
      if (cur_lvl == 2'd0 && mon[12]) return 3'd1;                        // R5
      l2h = l2d | l2rt | tge | (fgt & l2c);                               // R6
      l3h = l3d | (fgt & l3c);
      if (cur_lvl < 2'd2 && l2h) return 3'd2;
      if (!attop && l3h) return 3'd3;                                     // R7
      return 3'd0;
    end
    l2h = ((cls == 3'd0) ? l2p : (cls == 3'd1) ? l2r : l2d) | l2rt | tge; // R2 R4
    l3h = (cls == 3'd0) ? l3p : l3d;                                      // R3
    if (cur_lvl < 2'd2 && l2h) return 3'd2;
    if (cur_lvl != 2'd3 && l3h) return 3'd3;
    return 3'd0;                                                          // R9
  endfunction

  function automatic string tag_of();
    case (cls)
      3'd0, 3'd2: return "R3";
      3'd1:       return "R4";
      3'd3:       return "R6";
      3'd5:       return "R8";
      default:    return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp);
    checks++;
    if (result !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d lvl=%0d cls=%0d", tag, result, exp, cur_lvl, cls);
    end
  endtask

  task automatic clear_bits();
    {l2p, l2r, l2d, l2c, l2rt, tge, l3p, l3d, l3c, fgt, attop} = '0;
    mon = '0;
  endtask

  task automatic step(input string tag);
    logic [2:0] exp;
    exp = model();
    @(negedge clk);
    chk(tag, exp);
  endtask

  task automatic randomize_inputs();
    logic [31:0] r;
    r = $urandom;
    cur_lvl = r[1:0];
    cls = r[4:2];
    {l2p, l2r, l2d, l2c, l2rt, tge, l3p, l3d, l3c, fgt, attop} = r[15:5];
    if (r[16]) {l2p, l2r, l2d, l2c, l2rt, tge} = '0;
    if (r[17]) {l3p, l3d, l3c} = 3'b0;
    mon = $urandom;
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1;
    clear_bits();
    cur_lvl = 2'd0;
    cls = 3'd4;
    repeat (3) @(negedge clk);
    chk("R10_reset", 3'd0);
    rst = 1'b0;

    cls = 3'd0; cur_lvl = 2'd0;
    step("R9_idle");
    cls = 3'd4; l2rt = 1'b1;
    #1 chk("R10_latency", 3'd0);
    @(negedge clk); chk("R10_after_edge", 3'd4);
    clear_bits();

    cls = 3'd7; step("R1_code7");
    cls = 3'd6; l3d = 1'b1; step("R1_code6");
    clear_bits();

    cls = 3'd2; cur_lvl = 2'd1; tge = 1'b1; l3d = 1'b1; step("R2_tge_beats_l3");
    clear_bits();
    cls = 3'd1; cur_lvl = 2'd0; l2d = 1'b1; step("R4_rom_ignores_l2dbg");
    l2r = 1'b1; step("R4_rom_l2");
    clear_bits();
    cls = 3'd1; cur_lvl = 2'd2; l3p = 1'b1; step("R4_rom_ignores_l3pwr");
    l3d = 1'b1; step("R4_rom_l3dbg");
    clear_bits();
    cls = 3'd0; cur_lvl = 2'd2; l2p = 1'b1; l3p = 1'b1; step("R3_pwr_l3_at_lvl2");
    cur_lvl = 2'd3; step("R9_lvl3_quiet");
    clear_bits();

    cls = 3'd3; cur_lvl = 2'd0; mon[12] = 1'b1; l2d = 1'b1; l3d = 1'b1; step("R5_el1_priority");
    cur_lvl = 2'd1; step("R5_lvl1_skips");
    clear_bits();
    cls = 3'd3; cur_lvl = 2'd0; mon = 32'hFFFF_EFFF; step("R5_other_bits_ignored");
    clear_bits();
    cls = 3'd3; cur_lvl = 2'd1; l2c = 1'b1; l3c = 1'b1; step("R6_no_fgt");
    fgt = 1'b1; step("R6_fgt_l2");
    cur_lvl = 2'd2; step("R6_fgt_l3");
    clear_bits();
    cls = 3'd3; cur_lvl = 2'd3; l3d = 1'b1; step("R7_lvl3_not_top");
    attop = 1'b1; cur_lvl = 2'd2; step("R7_top_blocks");
    clear_bits();
    cls = 3'd5; cur_lvl = 2'd2; l3d = 1'b1; step("R8_vc_trap");
    cur_lvl = 2'd1; l2rt = 1'b1; step("R8_vc_lvl1");

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      step(tag_of());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule